// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a byte-wide parallel bus and the program/erase engine of a NOR flash array. It watches write cycles (address, data and a one-cycle write strobe) and only acts on instructions wrapped in a fixed unlock code. A program needs four write cycles and an erase needs six. Any cycle that breaks the expected pattern sends the interface back to plain read mode.

When a sequence is accepted, the block sends a one-cycle start pulse to the engine. For a program the pulse carries the target address and data byte. For an erase it carries a seven-bit mask of the blocks to clear. While the engine is busy, a status byte reports progress. Bit 7 is a data-polling bit, and bits 6 and 2 toggle on reads. A running erase can be paused so that blocks outside its mask can be programmed, and it can then be continued with the same mask.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the block is in read mode: busy, suspended, all pulses and the erase mask are 0, and status reads 0x00.
- R2: An instruction opens with data 0xAA at address 0x555 and then data 0x55 at address 0x2AA. The command byte follows at 0x555. Only address bits 10..0 are compared.
- R3: Unlock code, then 0xA0, then any fourth write: prog_start pulses high for one cycle, in the cycle after that write's clock edge. prog_addr and prog_data hold that write's address and data, and busy rises.
- R4: A wrong data byte or a wrong address in any cycle of a sequence returns the block to read mode. A later sequence must restart from its first cycle.
- R5: Unlock code, 0x80, unlock code, then 0x30 at any address selects the erase block holding that address. Blocks by address: 0x00000-0x0FFFF is 0, 0x10000-0x1FFFF is 1, 0x20000-0x2FFFF is 2, 0x30000-0x37FFF is 3, 0x38000-0x39FFF is 4, 0x3A000-0x3BFFF is 5, 0x3C000-0x3FFFF is 6. Mask bit n stands for block n.
- R6: Every further 0x30 write arrives before the window closes, adds its block to the mask and restarts the window. erase_start pulses exactly WIN_CYCLES clock edges after the last 0x30 write. Any other write inside the window aborts the erase and clears the mask.
- R7: A sixth-cycle write of 0x10 at 0x555 starts a chip erase. erase_start pulses in the next cycle with all seven mask bits set.
- R8: While busy, every write is ignored except the one named in R9. pe_done ends the operation, and at most one of the four pulses is high in any cycle.
- R9: Data 0xB0 written during an erase pulses susp_req, drops busy and sets suspended. During a program, 0xB0 has no effect.
- R10: While suspended, a program into a block outside the erase mask starts normally and leaves suspended set. A program into a masked block is dropped with no pulse.
- R11: While suspended and in read mode, a write of 0x30 pulses resume_req and makes the block busy again with the mask it had before.
- R12: While busy, status bit 7 is the inverse of bit 7 of the program data, or 0 during an erase. Bits 5, 4, 3, 1 and 0 are 0. When not busy, status is 0x00.
- R13: Status bit 6 inverts after each rd_en cycle while busy. Bit 2 inverts only on rd_en cycles during an erase whose rd_addr falls in a masked block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Status read strobe |
| rd_addr | input | ADDR_W | Status read address |
| pe_done | input | 1 | Engine finished the current operation |
| prog_start | output | 1 | Program start pulse |
| prog_addr | output | ADDR_W | Program target address |
| prog_data | output | 8 | Program data byte |
| erase_start | output | 1 | Erase start pulse |
| erase_mask | output | 7 | Blocks selected for erase |
| susp_req | output | 1 | Erase pause pulse |
| resume_req | output | 1 | Erase continue pulse |
| busy | output | 1 | Engine operation in progress |
| suspended | output | 1 | An erase is paused |
| status | output | 8 | Polling and toggle status byte |

## Verification
The sequence decoder is driven with several patterns:
- clean program and erase sequences;
- sequences broken by a shifted address in the second cycle, and by a stray write inside the erase window;
- unlock keys sent with high address bits set.

Together these separate full-pattern matching from matching on a prefix, and partial address decode from full decode. Multi-block erase is tried with confirms in the first and last blocks and with the window left open to its exact edge, which exposes a window that is off by one.

The pause path covers three cases: programs into a masked block and an unmasked block, and 0xB0 sent during a program, which must be ignored. Status reads inside and outside the erase mask check that bit 2 is gated by block while bit 6 is not.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

  localparam int NUM_BLK = 7;
  localparam int MATCH_W = 11;

  localparam logic [MATCH_W-1:0] ADR_MAIN = 11'h555;
  localparam logic [MATCH_W-1:0] ADR_AUX  = 11'h2AA;

  localparam logic [7:0] KEY_A    = 8'hAA;
  localparam logic [7:0] KEY_B    = 8'h55;
  localparam logic [7:0] OP_PROG  = 8'hA0;
  localparam logic [7:0] OP_ESET  = 8'h80;
  localparam logic [7:0] OP_BLK   = 8'h30;
  localparam logic [7:0] OP_CHIP  = 8'h10;
  localparam logic [7:0] OP_PAUSE = 8'hB0;

  typedef enum logic [3:0] {
    ST_READ, ST_U1, ST_U2, ST_PGM, ST_E1, ST_E2, ST_E3, ST_WIN,
    ST_BUSY_P, ST_BUSY_E
  } seq_state_t;

  // 8 KB page index (top five address bits) to erase block number
  function automatic logic [2:0] blk_of(input logic [4:0] page);
    if (page < 5'd8)        return 3'd0;
    else if (page < 5'd16)  return 3'd1;
    else if (page < 5'd24)  return 3'd2;
    else if (page < 5'd28)  return 3'd3;
    else if (page == 5'd28) return 3'd4;
    else if (page == 5'd29) return 3'd5;
    else                    return 3'd6;
  endfunction

  function automatic logic [NUM_BLK-1:0] blk_sel(input logic [4:0] page);
    return NUM_BLK'(1) << blk_of(page);
  endfunction

endpackage

// File: rtl/fcmd_window.sv
module fcmd_window #(
  parameter int WIN_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expire
);
  localparam int CNT_W = $clog2(WIN_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(WIN_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= CNT_TOP;
    else if (run && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expire = run && (cnt_q == CNT_W'(1));

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_TOP);

endmodule

// File: rtl/fcmd_seq.sv
module fcmd_seq
  import fcmd_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               pe_done,
  input  logic               win_expire,
  output logic               win_load,
  output logic               win_run,
  output logic               busy,
  output logic               erasing,
  output logic               suspended,
  output logic               prog_start,
  output logic               erase_start,
  output logic               susp_req,
  output logic               resume_req,
  output logic [ADDR_W-1:0]  prog_addr,
  output logic [7:0]         prog_data,
  output logic [NUM_BLK-1:0] erase_mask
);
  seq_state_t state_q;
  logic       susp_q;

  // named decode events
  logic       at_main, at_aux, hit_key_a, hit_key_b, is_blk;
  logic [4:0] wr_page;

  assign wr_page   = wr_addr[ADDR_W-1 -: 5];
  assign at_main   = wr_addr[MATCH_W-1:0] == ADR_MAIN;
  assign at_aux    = wr_addr[MATCH_W-1:0] == ADR_AUX;
  assign hit_key_a = at_main && wr_data == KEY_A;
  assign hit_key_b = at_aux && wr_data == KEY_B;
  assign is_blk    = wr_data == OP_BLK;

  assign win_load  = wr_en && is_blk && (state_q == ST_E3 || state_q == ST_WIN);
  assign win_run   = (state_q == ST_WIN) && !wr_en;
  assign busy      = (state_q == ST_BUSY_P) || (state_q == ST_BUSY_E);
  assign erasing   = state_q == ST_BUSY_E;
  assign suspended = susp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_READ;
      susp_q      <= 1'b0;
      prog_start  <= 1'b0;
      erase_start <= 1'b0;
      susp_req    <= 1'b0;
      resume_req  <= 1'b0;
      prog_addr   <= '0;
      prog_data   <= '0;
      erase_mask  <= '0;
    end else begin
      prog_start  <= 1'b0;
      erase_start <= 1'b0;
      susp_req    <= 1'b0;
      resume_req  <= 1'b0;
      case (state_q)
        ST_READ: if (wr_en) begin
          if (susp_q && is_blk) begin
            resume_req <= 1'b1;
            susp_q     <= 1'b0;
            state_q    <= ST_BUSY_E;
          end else if (hit_key_a) state_q <= ST_U1;
        end
        ST_U1: if (wr_en) state_q <= hit_key_b ? ST_U2 : ST_READ;
        ST_U2: if (wr_en) begin
          if (at_main && wr_data == OP_PROG)             state_q <= ST_PGM;
          else if (at_main && wr_data == OP_ESET && !susp_q) state_q <= ST_E1;
          else                                           state_q <= ST_READ;
        end
        ST_PGM: if (wr_en) begin
          if (susp_q && erase_mask[blk_of(wr_page)]) state_q <= ST_READ;
          else begin
            prog_start <= 1'b1;
            prog_addr  <= wr_addr;
            prog_data  <= wr_data;
            state_q    <= ST_BUSY_P;
          end
        end
        ST_E1: if (wr_en) state_q <= hit_key_a ? ST_E2 : ST_READ;
        ST_E2: if (wr_en) state_q <= hit_key_b ? ST_E3 : ST_READ;
        ST_E3: if (wr_en) begin
          if (is_blk) begin
            erase_mask <= blk_sel(wr_page);
            state_q    <= ST_WIN;
          end else if (at_main && wr_data == OP_CHIP) begin
            erase_mask  <= '1;
            erase_start <= 1'b1;
            state_q     <= ST_BUSY_E;
          end else state_q <= ST_READ;
        end
        ST_WIN: begin
          if (wr_en) begin
            if (is_blk) erase_mask <= erase_mask | blk_sel(wr_page);
            else begin
              erase_mask <= '0;
              state_q    <= ST_READ;
            end
          end else if (win_expire) begin
            erase_start <= 1'b1;
            state_q     <= ST_BUSY_E;
          end
        end
        ST_BUSY_P: if (pe_done) state_q <= ST_READ;
        ST_BUSY_E: begin
          if (pe_done) begin
            erase_mask <= '0;
            state_q    <= ST_READ;
          end else if (wr_en && wr_data == OP_PAUSE) begin
            susp_req <= 1'b1;
            susp_q   <= 1'b1;
            state_q  <= ST_READ;
          end
        end
        default: state_q <= ST_READ;
      endcase
    end
  end

  p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_start, erase_start, susp_req, resume_req}));
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pe_done && !wr_en) |=> busy);
  p_prog_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> busy);
  p_erase_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (erasing && erase_mask != '0));
  p_pause_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    susp_req |-> (!busy && suspended));
  p_resume_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> (erasing && erase_mask != '0 && !suspended));

endmodule

// File: rtl/fcmd_status.sv
module fcmd_status
  import fcmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busy,
  input  logic               erasing,
  input  logic               poll_bit,
  input  logic               rd_en,
  input  logic [4:0]         rd_page,
  input  logic [NUM_BLK-1:0] erase_mask,
  output logic [7:0]         status
);
  logic tog6_q, tog2_q, rd_hit;

  assign rd_hit = erase_mask[blk_of(rd_page)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog6_q <= 1'b0;
      tog2_q <= 1'b0;
    end else begin
      if (rd_en && busy)              tog6_q <= ~tog6_q;
      if (rd_en && erasing && rd_hit) tog2_q <= ~tog2_q;
    end
  end

  assign status = busy ? {poll_bit, tog6_q, 3'b000, tog2_q, 2'b00} : 8'h00;

  p_flip_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> (tog6_q != $past(tog6_q)));
  p_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en) |=> $stable(tog2_q) && $stable(tog6_q));

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import fcmd_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int WIN_CYCLES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic               pe_done,
  output logic               prog_start,
  output logic [ADDR_W-1:0]  prog_addr,
  output logic [7:0]         prog_data,
  output logic               erase_start,
  output logic [NUM_BLK-1:0] erase_mask,
  output logic               susp_req,
  output logic               resume_req,
  output logic               busy,
  output logic               suspended,
  output logic [7:0]         status
);
  logic win_load, win_run, win_expire, erasing, poll_bit;

  fcmd_window #(.WIN_CYCLES(WIN_CYCLES)) u_window (
    .clk(clk), .rst_n(rst_n), .load(win_load), .run(win_run), .expire(win_expire)
  );

  fcmd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pe_done(pe_done), .win_expire(win_expire), .win_load(win_load), .win_run(win_run),
    .busy(busy), .erasing(erasing), .suspended(suspended),
    .prog_start(prog_start), .erase_start(erase_start), .susp_req(susp_req),
    .resume_req(resume_req), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_mask(erase_mask)
  );

  assign poll_bit = erasing ? 1'b0 : ~prog_data[7];

  fcmd_status u_status (
    .clk(clk), .rst_n(rst_n), .busy(busy), .erasing(erasing), .poll_bit(poll_bit),
    .rd_en(rd_en), .rd_page(rd_addr[ADDR_W-1 -: 5]), .erase_mask(erase_mask),
    .status(status)
  );

endmodule

// File: tb/test_flash_cmd_if.sv
`timescale 1ns/1ps
module test_flash_cmd_if;
  localparam int AW = 18;
  localparam int W  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, pe_done = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic prog_start, erase_start, susp_req, resume_req, busy, suspended;
  logic [AW-1:0] prog_addr;
  logic [7:0] prog_data, status;
  logic [6:0] erase_mask;

  always #2.5 clk = ~clk;

  flash_cmd_if #(.ADDR_W(AW), .WIN_CYCLES(W)) i_flash_cmd_if (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .pe_done(pe_done),
    .prog_start(prog_start), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_start(erase_start), .erase_mask(erase_mask), .susp_req(susp_req),
    .resume_req(resume_req), .busy(busy), .suspended(suspended), .status(status)
  );

  int n_chk = 0, n_fail = 0;
  bit fin = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  // states: 0 read, 1/2 unlock, 3 program data, 4-6 erase unlock, 7 window, 8 prog busy, 9 erase busy
  int ms = 0, mcnt = 0;
  bit msusp = 0, mps = 0, mes = 0, msr = 0, mrr = 0, mt6 = 0, mt2 = 0;
  logic [6:0] mmask = '0;
  logic [AW-1:0] mpa = '0;
  logic [7:0] mpd = '0;

  function automatic int sec(input logic [AW-1:0] a);
    if (a < 18'h10000) return 0;
    if (a < 18'h20000) return 1;
    if (a < 18'h30000) return 2;
    if (a < 18'h38000) return 3;
    if (a < 18'h3A000) return 4;
    if (a < 18'h3C000) return 5;
    return 6;
  endfunction

  always @(posedge clk) begin
    bit ka, kb, m555;
    if (!rst_n) begin
      ms = 0; mcnt = 0; msusp = 0; mps = 0; mes = 0; msr = 0; mrr = 0;
      mt6 = 0; mt2 = 0; mmask = '0; mpa = '0; mpd = '0;
    end else begin
      if (rd_en && (ms == 8 || ms == 9)) mt6 = !mt6;
      if (rd_en && ms == 9 && mmask[sec(rd_addr)]) mt2 = !mt2;
      mps = 0; mes = 0; msr = 0; mrr = 0;
      m555 = (wr_addr % 2048) == 'h555;
      ka = m555 && wr_data == 8'hAA;
      kb = (wr_addr % 2048) == 'h2AA && wr_data == 8'h55;
      if (ms == 7 && !wr_en) begin
        if (mcnt == 1) begin mes = 1; ms = 9; end
        mcnt = mcnt - 1;
      end else if (ms == 8) begin
        if (pe_done) ms = 0;
      end else if (ms == 9) begin
        if (pe_done) begin ms = 0; mmask = '0; end
        else if (wr_en && wr_data == 8'hB0) begin msr = 1; msusp = 1; ms = 0; end
      end else if (wr_en) begin
        case (ms)
          0: if (msusp && wr_data == 8'h30) begin mrr = 1; msusp = 0; ms = 9; end
             else if (ka) ms = 1;
          1: ms = kb ? 2 : 0;
          2: ms = (m555 && wr_data == 8'hA0) ? 3 : (m555 && wr_data == 8'h80 && !msusp) ? 4 : 0;
          3: if (msusp && mmask[sec(wr_addr)]) ms = 0;
             else begin mps = 1; mpa = wr_addr; mpd = wr_data; ms = 8; end
          4: ms = ka ? 5 : 0;
          5: ms = kb ? 6 : 0;
          6: if (wr_data == 8'h30) begin mmask = 7'(1 << sec(wr_addr)); mcnt = W; ms = 7; end
             else if (m555 && wr_data == 8'h10) begin mmask = 7'h7F; mes = 1; ms = 9; end
             else ms = 0;
          7: if (wr_data == 8'h30) begin mmask[sec(wr_addr)] = 1'b1; mcnt = W; end
             else begin mmask = '0; ms = 0; end
          default: ms = 0;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    logic [7:0] est;
    bit mb;
    if (rst_n && !fin) begin
      mb = (ms == 8 || ms == 9);
      est = mb ? {(ms == 8) ? ~mpd[7] : 1'b0, mt6, 3'b000, mt2, 2'b00} : 8'h00;
      chk(busy == mb, "R8 busy", busy, mb);
      chk(suspended == msusp, "R9 suspended", suspended, msusp);
      chk(prog_start == mps, "R3 prog_start", prog_start, mps);
      chk(erase_start == mes, "R6 erase_start", erase_start, mes);
      chk(susp_req == msr, "R9 susp_req", susp_req, msr);
      chk(resume_req == mrr, "R11 resume_req", resume_req, mrr);
      chk(erase_mask == mmask, "R5 erase_mask", erase_mask, mmask);
      chk(status == est, "R12/R13 status", status, est);
      if (mps) chk(prog_addr == mpa && prog_data == mpd, "R3 prog fields",
                   {6'd0, prog_addr, prog_data}, {6'd0, mpa, mpd});
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic done();
    @(negedge clk); pe_done = 1'b1;
    @(negedge clk); pe_done = 1'b0;
  endtask
  task automatic unlock();
    wr(18'h00555, 8'hAA); wr(18'h002AA, 8'h55);
  endtask
  task automatic erase_setup();
    unlock(); wr(18'h00555, 8'h80); unlock();
  endtask

  task automatic finish_run();
    if (!fin) begin
      fin = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] s0;
    idle(4);
    chk(busy == 0 && status == 8'h00 && erase_mask == 0 && !suspended, "R1 reset state",
        {busy, suspended, erase_mask, status}, 0);
    rst_n = 1'b1;
    idle(2);
    chk(status == 8'h00 && !busy, "R1 idle after reset", status, 0);

    // R4: wrong address in cycle 2 breaks the sequence
    wr(18'h00555, 8'hAA); wr(18'h002AB, 8'h55); wr(18'h00555, 8'hA0); wr(18'h00100, 8'h12);
    chk(!prog_start && !busy, "R4 broken unlock ignored", {prog_start, busy}, 0);

    // R2/R3: program, high address bits set on the keys
    wr(18'h10555, 8'hAA); wr(18'h3E2AA, 8'h55); wr(18'h00555, 8'hA0); wr(18'h12345, 8'h5A);
    chk(prog_start == 1 && prog_addr == 18'h12345 && prog_data == 8'h5A, "R3 program start",
        {prog_start, prog_addr, prog_data}, {1'b1, 18'h12345, 8'h5A});
    chk(status[7] == 1'b1 && (status & 8'h3B) == 0, "R12 polling bit", status, 8'h80);
    s0 = status;
    rd(18'h00000);
    chk(status[6] != s0[6], "R13 bit6 toggles", status, s0 ^ 8'h40);
    wr(18'h00555, 8'hB0);
    chk(!susp_req && busy, "R9 pause ignored in program", {susp_req, busy}, 2'b01);
    unlock(); wr(18'h00555, 8'hA0); wr(18'h00200, 8'h01);
    chk(!prog_start && busy, "R8 writes ignored while busy", {prog_start, busy}, 2'b01);
    done();
    chk(!busy && status == 0, "R8 done ends busy", {busy, status}, 0);

    // R5/R6: multi-block erase, blocks 0 and 6
    erase_setup();
    wr(18'h00100, 8'h30); idle(3); wr(18'h3F000, 8'h30);
    idle(W - 1);
    chk(!erase_start, "R6 window not yet closed", erase_start, 0);
    idle(1);
    chk(erase_start == 1, "R6 start at window edge", erase_start, 1);
    chk(erase_mask == 7'b1000001, "R5 block mask", erase_mask, 7'b1000001);
    chk(status[7] == 1'b0, "R12 erase polling bit", status, 8'h00);
    s0 = status;
    rd(18'h3F000);
    chk(status[2] != s0[2], "R13 bit2 toggles in masked block", status, s0 ^ 8'h44);
    s0 = status;
    rd(18'h24000);
    chk(status[2] == s0[2] && status[6] != s0[6], "R13 bit2 quiet outside mask", status, s0 ^ 8'h40);

    // R9/R10/R11: pause, programs, continue
    wr(18'h00555, 8'hB0);
    chk(susp_req && !busy && suspended, "R9 pause", {susp_req, busy, suspended}, 3'b101);
    unlock(); wr(18'h00555, 8'hA0); wr(18'h00200, 8'h77);
    chk(!prog_start && !busy, "R10 masked program dropped", {prog_start, busy}, 0);
    unlock(); wr(18'h00555, 8'hA0); wr(18'h31000, 8'h88);
    chk(prog_start && prog_addr == 18'h31000, "R10 unmasked program", {prog_start, prog_addr}, {1'b1, 18'h31000});
    done();
    chk(suspended && !busy, "R10 still paused", {suspended, busy}, 2'b10);
    wr(18'h00000, 8'h30);
    chk(resume_req && busy && erase_mask == 7'b1000001, "R11 continue", {resume_req, busy, erase_mask}, {2'b11, 7'b1000001});
    done();

    // R7: chip erase
    erase_setup(); wr(18'h00555, 8'h10);
    chk(erase_start && erase_mask == 7'h7F, "R7 chip erase", {erase_start, erase_mask}, {1'b1, 7'h7F});
    done();

    // R6: stray write aborts window
    erase_setup(); wr(18'h20000, 8'h30); wr(18'h00555, 8'hF0);
    idle(W + 2);
    chk(!busy && erase_mask == 0, "R6 window abort", {busy, erase_mask}, 0);

    idle(2);
    finish_run();
  end
endmodule